// File: doc/BRIEF.md
# Charger Status Pin Duty Decoder

This block watches the open-drain status pin of a battery charger as a digital input and works out which of the charger's states that pin is signalling. The charger shows a steady level when it is charging or finished. For a fault it switches a carrier of about 35 kHz, and the fraction of each carrier period spent low identifies the fault. The decoder brings the pin into the clock domain and measures each carrier period from one falling edge to the next. It counts how many clock cycles of that period the pin was low, then turns the ratio into a state code.

A level that has not changed for a set number of carrier periods counts as steady. A reading lands on a fault value when it lies inside a narrow window around one of four nominal duties. A reading of exactly one half is what appears when the charger changes between its two duties for a fault. Such a reading is discarded without a report, and the next period is measured as usual. Each decision leaves the block as a one-cycle strobe together with a code that holds until the next strobe. A sampled pin cannot be paused, so there is no back-pressure: the consumer must take the code in the strobe cycle or read the held code later.

Top module: `status_duty_decoder`

## Requirements
- R1: After reset `rpt_valid_o` is 0 and `rpt_code_o` is 0 (no decision yet).
- R2: A pin held low with no edge for `QUIET_PERIODS*CARRIER_CYCLES` cycles gives a strobe with code 1 (charging). The strobe comes no sooner than that many cycles after the falling edge and no more than 4 cycles later.
- R3: A pin held high with no edge for `QUIET_PERIODS*CARRIER_CYCLES` cycles gives a strobe with code 2 (not charging). While the pin stays steady this repeats once per quiet interval.
- R4: A period whose low time is 1/16 or 15/16 of the period gives code 3 (temperature fault).
- R5: A period whose low time is 2/16 or 14/16 of the period gives code 4 (bad-cell fault).
- R6: With low time L and period P, a reading matches nominal k/16 when |32·L − 2k·P| < P, which is a window of just under ±1/32 of the period.
- R7: A period that matches no nominal value and is not exactly half gives code 7 (invalid). The code is only ever 0, 1, 2, 3, 4 or 7.
- R8: A period with 2·L = P gives no strobe. The period that follows is measured and reported normally.
- R9: The period runs from one falling edge to the next. While a pulse train continues, every complete period after the first falling edge gives exactly one decision.
- R10: `rpt_valid_o` is high for single cycles only. `rpt_code_o` changes only in a cycle where `rpt_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 1 | Raw status pin level, asynchronous to clk |
| rpt_valid_o | output | 1 | One-cycle strobe marking a new decision |
| rpt_code_o | output | 3 | Decoded state: 1 charging, 2 not charging, 3 temperature fault, 4 bad cell, 7 invalid |

## Verification
The hardest case to reach is the exact-half reading. To be rejected it needs a period whose low time is exactly half the period, counted in clocks. It also needs the period right after it to still be measured cleanly. The bench drives a 32/32 carrier for several periods and shows that no strobe appears. It then changes to a 2/16 train exactly on a period boundary and expects the next strobe to be a bad-cell code. The tolerance edges are found the same way, using low times one cycle inside and one cycle outside the window for a 64-cycle period.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  typedef enum logic [2:0] {
    ST_NONE     = 3'd0,
    ST_CHARGING = 3'd1,
    ST_IDLE     = 3'd2,
    ST_TEMP     = 3'd3,
    ST_BADCELL  = 3'd4,
    ST_INVALID  = 3'd7
  } state_code_t;
endpackage

// File: rtl/sdd_sync.sv
module sdd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign fall_o  = prev_q & ~sync_q;
  assign rise_o  = ~prev_q & sync_q;
endmodule

// File: rtl/sdd_meter.sv
module sdd_meter #(
  parameter int QUIET = 256,
  parameter int PW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          level_i,
  input  logic          fall_i,
  input  logic          rise_i,
  output logic          done_o,
  output logic [PW-1:0] per_o,
  output logic [PW-1:0] low_o,
  output logic          steady_o
);
  localparam int QW = $clog2(QUIET + 1);

  logic [QW-1:0] quiet_q;
  logic [PW-1:0] per_q, low_q;
  logic          armed_q;
  logic          edge_w;

  assign edge_w   = fall_i | rise_i;
  assign steady_o = !edge_w && (quiet_q == QW'(QUIET - 1));
  assign done_o   = fall_i & armed_q;
  assign per_o    = per_q;
  assign low_o    = low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_q <= '0;
    end else if (edge_w || steady_o) begin
      quiet_q <= '0;
    end else begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      per_q   <= '0;
      low_q   <= '0;
    end else if (fall_i) begin
      armed_q <= 1'b1;
      per_q   <= PW'(1);
      low_q   <= PW'(1);
    end else if (steady_o) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      per_q <= per_q + 1'b1;
      low_q <= low_q + PW'(!level_i);
    end
  end
endmodule

// File: rtl/sdd_classify.sv
module sdd_classify
  import sdd_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic [PW-1:0] per_i,
  input  logic [PW-1:0] low_i,
  output logic          half_o,
  output state_code_t   code_o
);
  localparam int XW = PW + 6;
  localparam int NNOM = 4;
  localparam logic [4:0] NOM16 [NNOM] = '{5'd1, 5'd15, 5'd2, 5'd14};

  logic [XW-1:0] scaled_low, per_x;
  logic [NNOM-1:0] hit;

  assign scaled_low = XW'(low_i) << 5;
  assign per_x      = XW'(per_i);
  assign half_o     = ({1'b0, low_i, 1'b0} == {2'b00, per_i});

  for (genvar g = 0; g < NNOM; g++) begin : g_nom
    logic [XW-1:0] target, diff;
    assign target = per_x * XW'(2 * NOM16[g]);
    assign diff   = (scaled_low >= target) ? scaled_low - target : target - scaled_low;
    assign hit[g] = diff < per_x;
  end

  always_comb begin
    if (|hit[1:0])      code_o = ST_TEMP;
    else if (|hit[3:2]) code_o = ST_BADCELL;
    else                code_o = ST_INVALID;
  end
endmodule

// File: rtl/status_duty_decoder.sv
module status_duty_decoder
  import sdd_pkg::*;
#(
  parameter int CARRIER_CYCLES = 5714,
  parameter int QUIET_PERIODS  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  output logic       rpt_valid_o,
  output logic [2:0] rpt_code_o
);
  localparam int QUIET = CARRIER_CYCLES * QUIET_PERIODS;
  localparam int PW    = $clog2(2 * QUIET + 2);

  logic          level_w, fall_w, rise_w;
  logic          done_w, steady_w, half_w;
  logic [PW-1:0] per_w, low_w;
  state_code_t   cls_w;

  sdd_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .level_o(level_w), .fall_o(fall_w), .rise_o(rise_w)
  );

  sdd_meter #(.QUIET(QUIET), .PW(PW)) u_meter (
    .clk(clk), .rst_n(rst_n), .level_i(level_w),
    .fall_i(fall_w), .rise_i(rise_w),
    .done_o(done_w), .per_o(per_w), .low_o(low_w), .steady_o(steady_w)
  );

  sdd_classify #(.PW(PW)) u_cls (
    .per_i(per_w), .low_i(low_w), .half_o(half_w), .code_o(cls_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt_valid_o <= 1'b0;
      rpt_code_o  <= ST_NONE;
    end else if (done_w && !half_w) begin
      rpt_valid_o <= 1'b1;
      rpt_code_o  <= cls_w;
    end else if (steady_w) begin
      rpt_valid_o <= 1'b1;
      rpt_code_o  <= level_w ? ST_IDLE : ST_CHARGING;
    end else begin
      rpt_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdd_checker.sv
module sdd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_i,
  input logic       rpt_valid_o,
  input logic [2:0] rpt_code_o
);
  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid_o |=> !rpt_valid_o);

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_valid_o |-> $stable(rpt_code_o));

  // R7
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid_o |-> (rpt_code_o inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd7}));

  // R2
  charge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid_o && rpt_code_o == 3'd1) |-> !$past(pin_i, 3));

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid_o && rpt_code_o == 3'd2) |-> $past(pin_i, 3));
endmodule

bind status_duty_decoder sdd_checker u_sdd_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
  .rpt_valid_o(rpt_valid_o), .rpt_code_o(rpt_code_o)
);

// File: tb/status_duty_decoder_test.sv
`timescale 1ns/1ps
module status_duty_decoder_test;
  localparam int CAR   = 64;
  localparam int QP    = 4;
  localparam int QUIET = CAR * QP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic       valid;
  logic [2:0] code;

  int  total = 0;
  int  bad = 0;
  bit  train_on = 1'b0;
  bit  lvl = 1'b1;
  int  lo_cyc = 4;
  int  hi_cyc = 60;

  always #2.5 clk = ~clk;

  status_duty_decoder #(.CARRIER_CYCLES(CAR), .QUIET_PERIODS(QP)) uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin),
    .rpt_valid_o(valid), .rpt_code_o(code)
  );

  initial begin : driver
    forever begin
      if (train_on) begin
        pin = 1'b0;
        repeat (lo_cyc) @(negedge clk);
        pin = 1'b1;
        repeat (hi_cyc) @(negedge clk);
      end else begin
        pin = lvl;
        @(negedge clk);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic get_next(input int maxwait, output int c, output int waited);
    c = -1;
    waited = 0;
    for (int i = 1; i <= maxwait; i++) begin
      @(negedge clk);
      if (valid) begin
        c = int'(code);
        waited = i;
        break;
      end
    end
    if (c >= 0) begin
      @(negedge clk);
      check(!valid, "R10 strobe width", int'(valid), 0);
      check(int'(code) == c, "R10 code hold", int'(code), c);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(valid == 1'b0, "R1 valid", int'(valid), 0);
    check(code == 3'd0, "R1 code", int'(code), 0);
  endtask

  task automatic t_idle;
    int c, w;
    train_on = 1'b0;
    lvl = 1'b1;
    get_next(QUIET + 20, c, w);
    check(c == 2, "R3 released pin", c, 2);
    get_next(QUIET + 4, c, w);
    check(c == 2 && w >= QUIET - 4, "R3 repeat interval", w, QUIET);
  endtask

  task automatic t_charge;
    int c, w;
    train_on = 1'b0;
    lvl = 1'b0;
    get_next(QUIET + 20, c, w);
    check(c == 1, "R2 held low", c, 1);
    check(w >= QUIET && w <= QUIET + 4, "R2 latency", w, QUIET + 3);
  endtask

  task automatic t_train(input int lo, input int hi, input int exp, input string req);
    int c, w;
    lo_cyc = lo;
    hi_cyc = hi;
    train_on = 1'b1;
    repeat (3 * (lo + hi)) @(negedge clk);
    get_next(2 * (lo + hi) + 4, c, w);
    check(c == exp, req, c, exp);
  endtask

  task automatic t_rate;
    int n = 0;
    lo_cyc = 4;
    hi_cyc = 60;
    train_on = 1'b1;
    repeat (3 * CAR) @(negedge clk);
    for (int i = 0; i < 10 * CAR; i++) begin
      @(negedge clk);
      if (valid) n++;
    end
    check(n == 10, "R9 one decision per period", n, 10);
  endtask

  task automatic t_half;
    int n = 0;
    int c, w;
    lo_cyc = 32;
    hi_cyc = 32;
    train_on = 1'b1;
    repeat (2 * CAR) @(negedge clk);
    for (int i = 0; i < 8 * CAR; i++) begin
      @(negedge clk);
      if (valid) n++;
    end
    check(n == 0, "R8 half reading suppressed", n, 0);
    lo_cyc = 8;
    hi_cyc = 56;
    get_next(3 * CAR, c, w);
    check(c == 4, "R8 next period measured", c, 4);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_charge();
    t_train(4, 60, 3, "R4 1/16 duty");
    t_train(60, 4, 3, "R4 15/16 duty");
    t_train(8, 56, 4, "R5 2/16 duty");
    t_train(56, 8, 4, "R5 14/16 duty");
    t_train(5, 59, 3, "R6 inside window");
    t_train(59, 5, 3, "R6 inside window high");
    t_train(6, 58, 7, "R6 outside window");
    t_train(20, 44, 7, "R7 unmatched duty");
    t_train(33, 31, 7, "R7 near half");
    t_rate();
    t_half();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule